// File: doc/BRIEF.md
# Page-Scanning Match Sequencer

This block sequences a bank of match engines that share their comparators across a small RAM each. Word `p` of every engine's RAM forms page `p` of the symbol stack, so one page of the whole stack is compared per clock. For each query symbol the sequencer walks the pages that can still hold match flags, in ascending order. It drives a shared page select and a scan enable, and during that cycle every engine compares and rewrites the flag of its word on the selected page.

The engines report two things for the page being scanned. The first is whether any flag is left on it. The second is whether a flag has moved from the page's last engine into the first engine of the next page. Pages left without flags are dropped for the following symbols. A carried flag adds the next page to the current walk, and since pages are visited in ascending order, that page is reached later in the same step. A header symbol restarts the walk on every page in a caller-supplied allow mask, because headers raise fresh flags wherever they match.

The caller strobes a symbol while the sequencer is idle, watches `busy`, and takes the one-cycle `done` pulse as the end of the step.

Top module: `pgscan_seq`

## Requirements
- R1: After reset `busy`, `done` and `scan_en` are low and no page is active, so a first non-header symbol scans nothing.
- R2: A header symbol (`sym_header`=1) scans exactly the pages whose bit is set in `page_allow` (bit p = page p), and it scans them in strictly ascending page order.
- R3: A non-header symbol scans exactly the pages that are active. A page is active when `page_flag[p]` was 1 during its most recent scan.
- R4: A page whose `page_flag` bit was 0 during its scan is never selected while `scan_en` is high on the next non-header symbol, unless a carry brings it back.
- R5: When `flag_carry` is high in the scan cycle of page p, and p is not the last page, page p+1 joins the current step. A carry out of the last page is ignored and does not wrap to page 0.
- R6: `done` is high for exactly one cycle. That cycle comes right after the last scan cycle, or right after the accept cycle when the step has no pages to scan. `busy` is low in the following cycle.
- R7: A `sym_valid` strobe while `busy` is high is ignored. It does not change the pages scanned, and no extra step follows.
- R8: `scan_en` is high exactly in the scan cycles. `busy` is high from the cycle after the accept cycle through the `done` cycle.
- R9: A header symbol with an all-zero `page_allow` scans no page and leaves no page active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | Query symbol strobe, accepted only while idle |
| sym_header | input | 1 | The strobed symbol is an expression header |
| page_allow | input | NUM_PAGES | Pages a header symbol may scan |
| page_flag | input | NUM_PAGES | Per-page flag presence after the engines update the scanned page |
| flag_carry | input | 1 | A flag moved from the scanned page into the next page |
| busy | output | 1 | A symbol step is in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| scan_en | output | 1 | The engines compare and update the selected page this cycle |
| page_sel | output | PAGE_W | Page selected for all engines |

## Verification
If the active set is wrong inside, it shows at the ports on the next non-header symbol. A page with no flags appears on `page_sel`, or a flagged page never does, and the step length moves away from one cycle per page plus one. A lost or misplaced carry shows within the same step, because the page after the carrying one then misses a scan or gets one it should not have. Order faults and a stretched or missing `done` show in the step where they happen.

// File: rtl/pgscan_pkg.sv
// Package: shared types for the page-scanning match sequencer.
// Assumes: nothing beyond a standard elaborator.
package pgscan_pkg;

    // Step controller state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } step_state_t;

endpackage

// File: rtl/pgscan_lowest.sv
// Module: pgscan_lowest
// Finds the lowest set bit of a page mask and returns its index.
// Assumes: NUM_PAGES >= 2. When no bit is set, idx is 0 and found is low.
module pgscan_lowest #(
    parameter int NUM_PAGES = 8,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic [NUM_PAGES-1:0] req,
    output logic                 found,
    output logic [PAGE_W-1:0]    idx
);

    // Priority search: the last match written, scanning downwards, is the lowest page
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (req[i]) idx = PAGE_W'(i);
        end
    end

endmodule

// File: rtl/pgscan_page_track.sv
// Module: pgscan_page_track
// Holds the pages still to be scanned in the current step (pending) and
// the pages that kept flags (active). A carry adds the page that follows.
// Assumes: pages are scanned in ascending order, one per scan_now cycle,
// and cur is always a pending page while scan_now is high.
module pgscan_page_track #(
    parameter int NUM_PAGES = 8,
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int LAST     = NUM_PAGES - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_PAGES-1:0] load_set,
    input  logic                 scan_now,
    input  logic [PAGE_W-1:0]    cur,
    input  logic                 flag_bit,
    input  logic                 carry,
    output logic [NUM_PAGES-1:0] pending_q,
    output logic [NUM_PAGES-1:0] pending_nxt,
    output logic [NUM_PAGES-1:0] active_q
);

    // Next pending set: retire the scanned page and add a carried-into page
    always_comb begin
        pending_nxt = pending_q;
        if (scan_now) begin
            pending_nxt[cur] = 1'b0;
            if (carry && (cur != PAGE_W'(LAST))) begin
                pending_nxt[cur + PAGE_W'(1)] = 1'b1;
            end
        end
    end

    // Pending and active masks: reload on accept, update per scanned page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            active_q  <= '0;
        end else if (load) begin
            pending_q <= load_set;
            active_q  <= '0;
        end else if (scan_now) begin
            pending_q     <= pending_nxt;
            active_q[cur] <= flag_bit;
        end
    end

    // R4: only a page that is pending in this step may be scanned
    assert_sel_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_now |-> pending_q[cur]);

    // R5: after the last page is scanned nothing remains pending, even with a carry
    assert_last_carry_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_now && (cur == PAGE_W'(LAST))) |=> (pending_q == '0));

    // R3: a scanned page is active afterwards exactly when it reported flags
    assert_active_follows_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_now && !load) |=> (active_q[$past(cur)] == $past(flag_bit)));

endmodule

// File: rtl/pgscan_seq.sv
// Module: pgscan_seq (top)
// Steps the shared page select across the pages that may hold match
// flags, once per query symbol, and pulses done at the end of the step.
// Assumes: page_flag and flag_carry are valid for page_sel in each cycle
// with scan_en high. sym_valid is taken only while idle.
module pgscan_seq
    import pgscan_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_valid,
    input  logic                 sym_header,
    input  logic [NUM_PAGES-1:0] page_allow,
    input  logic [NUM_PAGES-1:0] page_flag,
    input  logic                 flag_carry,
    output logic                 busy,
    output logic                 done,
    output logic                 scan_en,
    output logic [PAGE_W-1:0]    page_sel
);

    step_state_t          state_q;
    logic [PAGE_W-1:0]    cur_q;
    logic                 load;
    logic [NUM_PAGES-1:0] load_set;
    logic [NUM_PAGES-1:0] pending_q;
    logic [NUM_PAGES-1:0] pending_nxt;
    logic [NUM_PAGES-1:0] active_q;
    logic [NUM_PAGES-1:0] search_in;
    logic                 next_found;
    logic [PAGE_W-1:0]    next_idx;

    // Accept decode and the page set a new step starts from
    always_comb begin
        load     = (state_q == ST_IDLE) && sym_valid;
        load_set = sym_header ? page_allow : active_q;
    end

    // Search the start set when idle, else the set left after this scan
    always_comb begin
        search_in = (state_q == ST_IDLE) ? load_set : pending_nxt;
    end

    pgscan_lowest #(.NUM_PAGES(NUM_PAGES)) u_lowest (
        .req   (search_in),
        .found (next_found),
        .idx   (next_idx)
    );

    pgscan_page_track #(.NUM_PAGES(NUM_PAGES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_set    (load_set),
        .scan_now    (scan_en),
        .cur         (cur_q),
        .flag_bit    (page_flag[cur_q]),
        .carry       (flag_carry),
        .pending_q   (pending_q),
        .pending_nxt (pending_nxt),
        .active_q    (active_q)
    );

    // Step controller: idle -> scan pages in ascending order -> done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sym_valid) begin
                        if (next_found) begin
                            state_q <= ST_SCAN;
                            cur_q   <= next_idx;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_SCAN: begin
                    if (next_found) begin
                        cur_q <= next_idx;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the controller state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        scan_en  = (state_q == ST_SCAN);
        page_sel = cur_q;
    end

    // R6: done lasts exactly one cycle and is followed by idle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2: back-to-back scan cycles select strictly increasing pages
    assert_scan_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en)) |-> (page_sel > $past(page_sel)));

    // R7: an accepted symbol starts a step; busy rises only from idle
    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sym_valid) |=> busy);

    // R8: scan cycles only happen inside a busy step
    assert_scan_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (busy && !done));

endmodule

// File: tb/pgscan_seq_bench.sv
module pgscan_seq_bench;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sym_valid = 1'b0;
    logic          sym_header = 1'b0;
    logic [NP-1:0] page_allow = '0;
    logic [NP-1:0] page_flag;
    logic          flag_carry;
    logic          busy, done, scan_en;
    logic [2:0]    page_sel;

    logic [NP-1:0] cur_flags = '0;
    logic [NP-1:0] cur_carry = '0;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    always #10 clk = ~clk;  // 50 MHz

    pgscan_seq #(.NUM_PAGES(NP)) u_pgscan_seq (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_header(sym_header),
        .page_allow(page_allow), .page_flag(page_flag), .flag_carry(flag_carry),
        .busy(busy), .done(done), .scan_en(scan_en), .page_sel(page_sel)
    );

    // Engine model: flag presence and carry for the selected page
    always_comb begin
        page_flag  = cur_flags;
        flag_carry = scan_en & cur_carry[page_sel];
    end

    typedef struct packed {
        logic          hdr;
        logic [NP-1:0] allow;
        logic [NP-1:0] flags;
        logic [NP-1:0] carry;
        logic          inject;
        logic [NP-1:0] exp_scan;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00},  // R1 nothing active after reset
        '{1'b1, 8'hFF, 8'h25, 8'h00, 1'b0, 8'hFF},  // R2 header, all pages
        '{1'b0, 8'h00, 8'h25, 8'h00, 1'b0, 8'h25},  // R3 only flagged pages
        '{1'b0, 8'h00, 8'h0C, 8'h04, 1'b0, 8'h2D},  // R5 carry 2->3 joins step
        '{1'b0, 8'h00, 8'h18, 8'h08, 1'b0, 8'h1C},  // R4 pages 0,5 dropped; carry 3->4
        '{1'b1, 8'hF0, 8'h80, 8'h80, 1'b0, 8'hF0},  // R2 restricted header
        '{1'b0, 8'h00, 8'h80, 8'h80, 1'b0, 8'h80},  // R5 last-page carry ignored
        '{1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00},  // R9 empty allow mask
        '{1'b0, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00},  // R9 nothing left active
        '{1'b1, 8'h01, 8'h02, 8'h03, 1'b0, 8'h07},  // R5 chained carries 0->1->2
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h02},  // R3 only page 1 kept flags
        '{1'b1, 8'h0F, 8'h0F, 8'h00, 1'b1, 8'h0F},  // R7 strobe during step
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0F}   // R7 injected header not taken
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_symbol(input vec_t v);
        logic [NP-1:0] seen = '0;
        int            cycles = 1;
        int            last = -1;
        bit            order_ok = 1'b1;
        bit            idle_ok = 1'b1;
        @(negedge clk);
        cur_flags  = v.flags;
        cur_carry  = v.carry;
        sym_header = v.hdr;
        page_allow = v.allow;
        sym_valid  = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        while (1) begin
            if (!busy) order_ok = 1'b0;                        // R8
            if (scan_en) begin
                if (int'(page_sel) <= last) order_ok = 1'b0;   // R2
                if (!v.exp_scan[page_sel]) order_ok = 1'b0;    // R4
                seen[page_sel] = 1'b1;
                last = int'(page_sel);
            end
            if (done) break;
            if (cycles > 40) break;
            if (v.inject && cycles == 2) begin
                sym_valid  = 1'b1;
                sym_header = 1'b1;
                page_allow = 8'hF0;
            end
            @(negedge clk);
            sym_valid = 1'b0;
            cycles++;
        end
        check(seen == v.exp_scan, "R2/R3/R5 page set", int'(seen), int'(v.exp_scan));
        check(order_ok, "R2/R4/R8 order and subset", 0, 1);
        check(cycles == $countones(v.exp_scan) + 1, "R6 step length",
              cycles, $countones(v.exp_scan) + 1);
        @(negedge clk);
        check(!done && !busy, "R6 single done", int'({done, busy}), 0);
        if (v.inject) begin
            for (int k = 0; k < 3; k++) begin
                if (busy || scan_en) idle_ok = 1'b0;
                @(negedge clk);
            end
            check(idle_ok, "R7 no extra step", 0, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check(!busy && !done && !scan_en, "R1 reset outputs",
              int'({busy, done, scan_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !scan_en, "R1 idle after reset",
              int'({busy, done, scan_en}), 0);
        for (int i = 0; i < NV; i++) run_symbol(VECS[i]);

        // Directed: reset in mid-step clears activity (R1)
        run_symbol('{1'b1, 8'hFF, 8'hFF, 8'h00, 1'b0, 8'hFF});
        @(negedge clk);
        cur_flags = 8'hFF; sym_header = 1'b0; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!busy && !scan_en, "R1 reset aborts step", int'({busy, scan_en}), 0);
        rst_n = 1'b1;
        run_symbol('{1'b0, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00});  // R1 active cleared

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule